// File: doc/BRIEF.md
# Register-File Load/Store Transfer Unit

This block executes the data-movement instructions of a small 8-bit controller core. It owns a 32-entry by 8-bit register file and a 608-byte data memory. It accepts one 16-bit instruction word at a time and carries out the move, load or store it encodes. Three 16-bit address pointers are held inside the register file as register pairs. The pointer is R27:R26 for the X form, R29:R28 for Y and R31:R30 for Z, with the low byte in the even register. The auto-increment and auto-decrement forms update these pairs in place.

An instruction is accepted on a cycle where `in_valid` and `in_ready` are both high. Single-word instructions take effect at the accepting edge. `done` is high for the cycle that follows. The direct load is the one two-word instruction. It drops `in_ready` for one cycle and takes its data address from `in_word2` at the next edge, so the issuer must hold that input until then. `done` follows that second edge. Two side ports read the register file and the data memory combinationally. They change no state.

Top module: `xfer_unit`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers, drives `done` low and leaves `in_ready` high.
- R2: Word `0010 11rd dddd rrrr` copies register r into register d. The 5-bit index d is bits 8..4. The 5-bit index r is bit 9 followed by bits 3..0.
- R3: Word `0000 0001 dddd rrrr` copies the pair at 2r+1:2r into the pair at 2d+1:2d. Each 4-bit field is a pair number.
- R4: Word `1110 KKKK dddd KKKK` writes the constant formed from bits 11..8 (high nibble) and bits 3..0 (low nibble) into register 16+d.
- R5: Word `1001 000d dddd xxxx` loads register d through the X pointer. Low nibble 1100 reads at X. Low nibble 1101 reads at X and then adds one to X. Low nibble 1110 subtracts one from X and then reads. Pointer arithmetic is 16-bit and wraps, so 0x0000 minus one gives 0xFFFF.
- R6: The same prefix with low nibble 1001 or 1010 does the post-increment or pre-decrement load through Y. Low nibble 0001 or 0010 does the same through Z.
- R7: Word `10q0 qq0d dddd pqqq` loads register d from the pointer plus a 6-bit offset q, with the bits of q taken in order 13, 11, 10, 2, 1, 0. p=1 selects Y and p=0 selects Z. The pointer is left unchanged, and q=0 gives the plain Y or Z load.
- R8: Word `1001 000d dddd 0000` is a direct load. It drops `in_ready` and keeps `done` low for one cycle. It then loads register d from the address on `in_word2` and raises `done` with `in_ready` high again.
- R9: Word `1001 001r rrrr 1100` stores register r at address X. Memory addresses 0 to 607 exist. A store at 608 or above changes nothing, not even the location its low address bits alias. A load from 608 or above returns 0x00.
- R10: When a pointer-updating load names a byte of its own pointer as destination, that byte receives the loaded data and the other byte receives the updated pointer.
- R11: Every accepted single-word instruction gives a `done` pulse of exactly one cycle in the next cycle. An unrecognised word also pulses `done` and changes no register. `done` stays low while nothing is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Unit can accept a word this cycle |
| in_word | input | 16 | Instruction word |
| in_word2 | input | 16 | Data address for the direct load, sampled one edge after acceptance |
| done | output | 1 | One-cycle completion pulse |
| peek_reg_sel | input | 5 | Register index for the observation port |
| peek_reg_val | output | 8 | Contents of the selected register |
| peek_mem_addr | input | 10 | Memory address for the observation port |
| peek_mem_val | output | 8 | Contents of that address, 0x00 when out of range |

## Verification
The properties assume that `in_word2` holds the direct-load address from acceptance through the following edge. They also assume that `in_valid` has no effect while `in_ready` is low, so a word offered during the stall is neither taken nor completed. The stimulus raises `in_valid` for exactly one cycle per instruction and only while the unit is ready. It leaves `in_word2` untouched until the next issue. Reset is applied only at the start, before any instruction. The bench reads memory only at locations it has stored to earlier or at addresses outside the array, so no expected value depends on uninitialised storage.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int RF_DEPTH   = 32;
  localparam int RF_WIDTH   = 8;
  localparam int DMEM_BYTES = 608;
  localparam int IWORD      = 16;
  localparam int DISP_W     = 6;

  typedef enum logic [2:0] {
    OP_NOP, OP_MOV, OP_MOVW, OP_LDI, OP_LDPTR, OP_LDDISP, OP_LDDIR, OP_STX
  } op_e;

  typedef enum logic [1:0] { PT_X, PT_Y, PT_Z } ptr_e;

  typedef enum logic [1:0] { AM_PLAIN, AM_POST, AM_PRE } amode_e;

  typedef struct packed {
    op_e               op;
    logic [4:0]        rd;
    logic [4:0]        rs;
    logic [7:0]        imm;
    ptr_e              ptr;
    amode_e            mode;
    logic [DISP_W-1:0] disp;
  } dec_t;

  // Index of the low byte of each pointer pair
  function automatic logic [4:0] ptr_base(ptr_e p);
    case (p)
      PT_Y:    return 5'd28;
      PT_Z:    return 5'd30;
      default: return 5'd26;
    endcase
  endfunction
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
(
  input  logic [IWORD-1:0] word,
  output dec_t             dec
);
  always_comb begin
    dec      = '0;
    dec.op   = OP_NOP;
    dec.ptr  = PT_X;
    dec.mode = AM_PLAIN;
    dec.rd   = word[8:4];
    if (word[15:10] == 6'b001011) begin
      dec.op = OP_MOV;
      dec.rs = {word[9], word[3:0]};
    end else if (word[15:8] == 8'h01) begin
      dec.op = OP_MOVW;
      dec.rd = {word[7:4], 1'b0};
      dec.rs = {word[3:0], 1'b0};
    end else if (word[15:12] == 4'hE) begin
      dec.op  = OP_LDI;
      dec.rd  = {1'b1, word[7:4]};
      dec.imm = {word[11:8], word[3:0]};
    end else if (word[15:9] == 7'b1001000) begin
      case (word[3:0])
        4'b0000: dec.op = OP_LDDIR;
        4'b1100: begin dec.op = OP_LDPTR; dec.ptr = PT_X; dec.mode = AM_PLAIN; end
        4'b1101: begin dec.op = OP_LDPTR; dec.ptr = PT_X; dec.mode = AM_POST;  end
        4'b1110: begin dec.op = OP_LDPTR; dec.ptr = PT_X; dec.mode = AM_PRE;   end
        4'b1001: begin dec.op = OP_LDPTR; dec.ptr = PT_Y; dec.mode = AM_POST;  end
        4'b1010: begin dec.op = OP_LDPTR; dec.ptr = PT_Y; dec.mode = AM_PRE;   end
        4'b0001: begin dec.op = OP_LDPTR; dec.ptr = PT_Z; dec.mode = AM_POST;  end
        4'b0010: begin dec.op = OP_LDPTR; dec.ptr = PT_Z; dec.mode = AM_PRE;   end
        default: dec.op = OP_NOP;
      endcase
    end else if (word[15:9] == 7'b1001001) begin
      if (word[3:0] == 4'b1100) begin
        dec.op = OP_STX;
        dec.rs = word[8:4];
      end
    end else if (word[15:14] == 2'b10 && !word[12] && !word[9]) begin
      dec.op   = OP_LDDISP;
      dec.ptr  = word[3] ? PT_Y : PT_Z;
      dec.disp = {word[13], word[11:10], word[2:0]};
    end
  end
endmodule

// File: rtl/xfer_agu.sv
module xfer_agu
  import xfer_pkg::*;
#(
  parameter int PW    = 16,
  parameter int DISPW = DISP_W
) (
  input  logic [PW-1:0]    ptr_in,
  input  amode_e           mode,
  input  logic [DISPW-1:0] disp,
  output logic [PW-1:0]    ea,
  output logic [PW-1:0]    ptr_out
);
  always_comb begin
    ptr_out = ptr_in;
    ea      = ptr_in + PW'(disp);
    case (mode)
      AM_POST: begin
        ea      = ptr_in;
        ptr_out = ptr_in + PW'(1);
      end
      AM_PRE: begin
        ptr_out = ptr_in - PW'(1);
        ea      = ptr_in - PW'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xfer_regfile.sv
module xfer_regfile #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     a_we,
  input  logic [$clog2(DEPTH)-1:0] a_idx,
  input  logic [W-1:0]             a_dat,
  input  logic                     b_we,
  input  logic [$clog2(DEPTH)-1:0] b_idx,
  input  logic [W-1:0]             b_dat,
  input  logic                     p_we,
  input  logic [$clog2(DEPTH)-1:0] p_idx,
  input  logic [2*W-1:0]           p_val,
  output logic [DEPTH-1:0][W-1:0]  regs
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] p_idx_hi;
  assign p_idx_hi = p_idx + IW'(1);

  // Data ports outrank the pointer port on the same entry
  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (a_we && a_idx == IW'(i))
          regs[i] <= a_dat;
        else if (b_we && b_idx == IW'(i))
          regs[i] <= b_dat;
        else if (p_we && p_idx == IW'(i))
          regs[i] <= p_val[W-1:0];
        else if (p_we && p_idx_hi == IW'(i))
          regs[i] <= p_val[2*W-1:W];
      end
    end
  end
endmodule

// File: rtl/xfer_dmem.sv
module xfer_dmem #(
  parameter int DEPTH = 608,
  parameter int W     = 8,
  parameter int AW    = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [W-1:0]             wdata,
  input  logic [AW-1:0]            raddr,
  output logic [W-1:0]             rdata,
  input  logic [$clog2(DEPTH)-1:0] paddr,
  output logic [W-1:0]             pdata
);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr < AW'(DEPTH))
      mem[waddr[IW-1:0]] <= wdata;
  end

  assign rdata = (raddr < AW'(DEPTH)) ? mem[raddr[IW-1:0]] : '0;
  assign pdata = (paddr < IW'(DEPTH)) ? mem[paddr] : '0;
endmodule

// File: rtl/xfer_unit.sv
module xfer_unit
  import xfer_pkg::*;
#(
  parameter int NREG  = RF_DEPTH,
  parameter int W     = RF_WIDTH,
  parameter int MEMSZ = DMEM_BYTES,
  parameter int IW    = IWORD
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [IW-1:0]            in_word,
  input  logic [IW-1:0]            in_word2,
  output logic                     done,
  input  logic [$clog2(NREG)-1:0]  peek_reg_sel,
  output logic [W-1:0]             peek_reg_val,
  input  logic [$clog2(MEMSZ)-1:0] peek_mem_addr,
  output logic [W-1:0]             peek_mem_val
);
  localparam int RIW = $clog2(NREG);
  localparam int PW  = 2 * W;

  dec_t                   dec;
  logic [NREG-1:0][W-1:0] regs;
  logic                   ready_q, done_q, pend_q;
  logic [RIW-1:0]         pend_rd_q;
  logic                   accept, lds_start;
  logic [RIW-1:0]         ptr_lo;
  logic [PW-1:0]          ptr_cur, ptr_nxt, ea;
  logic [PW-1:0]          mem_raddr;
  logic [W-1:0]           mem_rdata;
  logic                   mem_we;
  logic                   a_we, b_we, p_we;
  logic [RIW-1:0]         a_idx, b_idx;
  logic [W-1:0]           a_dat, b_dat;

  xfer_decode u_dec (.word(in_word), .dec(dec));

  assign accept    = in_valid && ready_q;
  assign lds_start = accept && dec.op == OP_LDDIR;

  assign ptr_lo  = ptr_base(dec.ptr);
  assign ptr_cur = {regs[ptr_lo | RIW'(1)], regs[ptr_lo]};

  xfer_agu #(.PW(PW), .DISPW(DISP_W)) u_agu (
    .ptr_in (ptr_cur),
    .mode   (dec.mode),
    .disp   (dec.disp),
    .ea     (ea),
    .ptr_out(ptr_nxt)
  );

  assign mem_raddr = pend_q ? in_word2 : ea;
  assign mem_we    = accept && dec.op == OP_STX;

  xfer_dmem #(.DEPTH(MEMSZ), .W(W), .AW(PW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(ea),
    .wdata(regs[dec.rs]),
    .raddr(mem_raddr),
    .rdata(mem_rdata),
    .paddr(peek_mem_addr),
    .pdata(peek_mem_val)
  );

  always_comb begin
    a_we  = 1'b0;
    a_idx = dec.rd;
    a_dat = '0;
    b_we  = 1'b0;
    b_idx = dec.rd | RIW'(1);
    b_dat = regs[dec.rs | RIW'(1)];
    p_we  = 1'b0;
    if (pend_q) begin
      a_we  = 1'b1;
      a_idx = pend_rd_q;
      a_dat = mem_rdata;
    end else if (accept) begin
      case (dec.op)
        OP_MOV:    begin a_we = 1'b1; a_dat = regs[dec.rs]; end
        OP_MOVW:   begin a_we = 1'b1; a_dat = regs[dec.rs]; b_we = 1'b1; end
        OP_LDI:    begin a_we = 1'b1; a_dat = dec.imm; end
        OP_LDPTR:  begin a_we = 1'b1; a_dat = mem_rdata; p_we = (dec.mode != AM_PLAIN); end
        OP_LDDISP: begin a_we = 1'b1; a_dat = mem_rdata; end
        default:   ;
      endcase
    end
  end

  xfer_regfile #(.DEPTH(NREG), .W(W)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .a_we (a_we),
    .a_idx(a_idx),
    .a_dat(a_dat),
    .b_we (b_we),
    .b_idx(b_idx),
    .b_dat(b_dat),
    .p_we (p_we),
    .p_idx(ptr_lo),
    .p_val(ptr_nxt),
    .regs (regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b1;
      done_q    <= 1'b0;
      pend_q    <= 1'b0;
      pend_rd_q <= '0;
    end else begin
      done_q <= pend_q || (accept && dec.op != OP_LDDIR);
      if (pend_q) begin
        pend_q  <= 1'b0;
        ready_q <= 1'b1;
      end else if (lds_start) begin
        pend_q    <= 1'b1;
        ready_q   <= 1'b0;
        pend_rd_q <= dec.rd;
      end
    end
  end

  assign in_ready     = ready_q;
  assign done         = done_q;
  assign peek_reg_val = regs[peek_reg_sel];
endmodule

// File: rtl/xfer_unit_chk.sv
module xfer_unit_chk (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic done,
  input logic accept,
  input logic lds_start,
  input logic mem_we
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!done && in_ready));

  // R11
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !lds_start) |=> done);

  // R11
  quiet_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !accept) |=> !done);

  // R8
  lds_stall_chk: assert property (@(posedge clk) disable iff (rst)
    lds_start |=> (!in_ready && !done));

  // R8
  lds_finish_chk: assert property (@(posedge clk) disable iff (rst)
    lds_start |=> ##1 (done && in_ready));

  // R9
  store_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> done);
endmodule

bind xfer_unit xfer_unit_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .done     (done),
  .accept   (accept),
  .lds_start(lds_start),
  .mem_we   (mem_we)
);

// File: tb/xfer_unit_tb_top.sv
module xfer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_word, in_word2;
  logic        done;
  logic [4:0]  peek_reg_sel;
  logic [7:0]  peek_reg_val;
  logic [9:0]  peek_mem_addr;
  logic [7:0]  peek_mem_val;

  always #4 clk = ~clk;

  xfer_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_word2(in_word2), .done(done),
    .peek_reg_sel(peek_reg_sel), .peek_reg_val(peek_reg_val),
    .peek_mem_addr(peek_mem_addr), .peek_mem_val(peek_mem_val)
  );

  typedef struct {
    bit         is_mem;
    int         loc;
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t       sb[$];
  int         n_chk = 0;
  int         n_bad = 0;
  bit         mon_busy = 1'b0;
  logic [7:0] mrf  [32];
  logic [7:0] mmem [608];

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares them through the observation ports
  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        mon_busy = 1'b1;
        e = sb.pop_front();
        if (e.is_mem) peek_mem_addr = e.loc[9:0];
        else          peek_reg_sel  = e.loc[4:0];
        #1;
        if (e.is_mem)
          check(e.req, $sformatf("mem[%0d]", e.loc), {8'h00, peek_mem_val}, {8'h00, e.val});
        else
          check(e.req, $sformatf("reg[%0d]", e.loc), {8'h00, peek_reg_val}, {8'h00, e.val});
        mon_busy = 1'b0;
      end
    end
  end

  task automatic exp_reg(input int i, input string req);
    sb.push_back('{1'b0, i, mrf[i], req});
  endtask

  task automatic exp_mem(input int a, input string req);
    sb.push_back('{1'b1, a, mmem[a], req});
  endtask

  task automatic drain();
    wait (sb.size() == 0 && !mon_busy);
  endtask

  task automatic exp_all_regs(input string req);
    for (int i = 0; i < 32; i++) exp_reg(i, req);
    drain();
  endtask

  function automatic logic [15:0] getp(input int base);
    return {mrf[base+1], mrf[base]};
  endfunction

  function automatic logic [7:0] memrd(input logic [15:0] a);
    return (a < 16'd608) ? mmem[a] : 8'h00;
  endfunction

  task automatic issue(input logic [15:0] w, input logic [15:0] w2,
                       input bit two, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; in_word2 = w2;
    @(negedge clk);
    in_valid = 1'b0;
    if (two) begin
      check("R8", "in_ready during second word", {15'd0, in_ready}, 16'd0);
      check("R8", "done before second word", {15'd0, done}, 16'd0);
      @(negedge clk);
    end
    check(req, "done pulse", {15'd0, done}, 16'd1);
    @(negedge clk);
    check("R11", "done returns low", {15'd0, done}, 16'd0);
  endtask

  task automatic do_ldi(input int d, input logic [7:0] k, input string req);
    logic [3:0] f = 4'(d - 16);
    mrf[d] = k;
    issue({4'hE, k[7:4], f, k[3:0]}, 16'h0, 1'b0, req);
    exp_reg(d, req); drain();
  endtask

  task automatic do_mov(input int d, input int r, input string req);
    logic [4:0] dd = 5'(d);
    logic [4:0] rr = 5'(r);
    mrf[d] = mrf[r];
    issue({6'b001011, rr[4], dd, rr[3:0]}, 16'h0, 1'b0, req);
    exp_reg(d, req); drain();
  endtask

  task automatic do_movw(input int d, input int r, input string req);
    logic [7:0] lo = mrf[r];
    logic [7:0] hi = mrf[r+1];
    mrf[d] = lo; mrf[d+1] = hi;
    issue({8'h01, 4'(d/2), 4'(r/2)}, 16'h0, 1'b0, req);
    exp_reg(d, req); exp_reg(d+1, req); drain();
  endtask

  // mode: 0 plain (X only), 1 post-increment, 2 pre-decrement
  task automatic do_ldptr(input int base, input int mode, input int d, input string req);
    logic [3:0]  nib;
    logic [15:0] p;
    logic [7:0]  data;
    if (base == 26)      nib = (mode == 0) ? 4'b1100 : (mode == 1) ? 4'b1101 : 4'b1110;
    else if (base == 28) nib = (mode == 1) ? 4'b1001 : 4'b1010;
    else                 nib = (mode == 1) ? 4'b0001 : 4'b0010;
    p = getp(base);
    if (mode == 2) p = p - 16'd1;
    data = memrd(p);
    if (mode == 1) p = p + 16'd1;
    mrf[base] = p[7:0]; mrf[base+1] = p[15:8];
    mrf[d] = data;
    issue({7'b1001000, 5'(d), nib}, 16'h0, 1'b0, req);
    exp_reg(d, req); exp_reg(base, req); exp_reg(base+1, req); drain();
  endtask

  task automatic do_ldd(input int base, input logic [5:0] q, input int d, input string req);
    logic sel_y = (base == 28);
    mrf[d] = memrd(getp(base) + {10'd0, q});
    issue({2'b10, q[5], 1'b0, q[4:3], 1'b0, 5'(d), sel_y, q[2:0]}, 16'h0, 1'b0, req);
    exp_reg(d, req); exp_reg(base, req); exp_reg(base+1, req); drain();
  endtask

  task automatic do_lds(input int d, input logic [15:0] a, input string req);
    mrf[d] = memrd(a);
    issue({7'b1001000, 5'(d), 4'b0000}, a, 1'b1, req);
    exp_reg(d, req); drain();
  endtask

  task automatic do_stx(input int r, input string req);
    logic [15:0] a = getp(26);
    if (a < 16'd608) mmem[a] = mrf[r];
    issue({7'b1001001, 5'(r), 4'b1100}, 16'h0, 1'b0, req);
    if (a < 16'd608) exp_mem(int'(a), req);
    else if (a[9:0] < 10'd608) exp_mem(int'(a[9:0]), req);
    drain();
  endtask

  task automatic fill(input logic [15:0] a, input logic [7:0] v);
    do_ldi(26, a[7:0], "R4");
    do_ldi(27, a[15:8], "R4");
    do_ldi(18, v, "R4");
    do_stx(18, "R9");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (40000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin : driver
    for (int i = 0; i < 32; i++)  mrf[i]  = 8'h00;
    for (int i = 0; i < 608; i++) mmem[i] = 8'h00;
    rst = 1'b1; in_valid = 1'b0; in_word = '0; in_word2 = '0;
    peek_reg_sel = '0; peek_mem_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "in_ready after reset", {15'd0, in_ready}, 16'd1);
    check("R1", "done after reset", {15'd0, done}, 16'd0);
    exp_all_regs("R1");

    // R4 / R2 / R3
    do_ldi(16, 8'hA5, "R4");
    do_ldi(31, 8'h3C, "R4");
    do_ldi(17, 8'h96, "R4");
    do_mov(0, 16, "R2");
    do_mov(21, 31, "R2");
    do_mov(5, 0, "R2");
    do_movw(2, 30, "R3");
    do_movw(14, 16, "R3");

    // R9 stores that seed memory
    fill(16'h003F, 8'h11); fill(16'h0040, 8'h22); fill(16'h0041, 8'h33);
    fill(16'h0042, 8'h44); fill(16'h0043, 8'h55); fill(16'h0044, 8'h66);
    fill(16'h007F, 8'h77); fill(16'h00FF, 8'h88); fill(16'h025F, 8'h99);
    fill(16'h0005, 8'h5A);

    // R5 X forms
    do_ldi(26, 8'h40, "R4"); do_ldi(27, 8'h00, "R4");
    do_ldptr(26, 0, 3, "R5");
    do_ldptr(26, 1, 4, "R5");
    do_ldptr(26, 2, 6, "R5");

    // R6 Y and Z forms
    do_ldi(28, 8'h41, "R4"); do_ldi(29, 8'h00, "R4");
    do_ldptr(28, 1, 7, "R6");
    do_ldptr(28, 2, 8, "R6");
    do_ldi(30, 8'h43, "R4"); do_ldi(31, 8'h00, "R4");
    do_ldptr(30, 1, 9, "R6");
    do_ldptr(30, 2, 10, "R6");

    // R7 displacement
    do_ldd(28, 6'd0, 11, "R7");
    do_ldd(28, 6'd62, 12, "R7");
    do_ldd(30, 6'd0, 13, "R7");
    do_ldd(30, 6'd1, 1, "R7");

    // R8 direct load, R9 out-of-range read
    do_lds(14, 16'h025F, "R8");
    do_lds(15, 16'h0260, "R9");

    // R5 wrap in both directions
    do_ldi(26, 8'h00, "R4"); do_ldi(27, 8'h00, "R4");
    do_ldptr(26, 2, 17, "R5");
    do_ldptr(26, 1, 19, "R5");

    // R10 destination inside the moving pointer
    do_ldi(26, 8'hFF, "R4"); do_ldi(27, 8'h00, "R4");
    do_ldptr(26, 1, 27, "R10");
    do_ldi(30, 8'h00, "R4"); do_ldi(31, 8'h01, "R4");
    do_ldptr(30, 2, 30, "R10");

    // R9 store above the array is dropped, aliased byte untouched
    do_ldi(26, 8'h05, "R4"); do_ldi(27, 8'h04, "R4");
    do_stx(16, "R9");
    do_lds(20, 16'h0405, "R9");

    // R11 unrecognised word changes nothing
    issue(16'h1234, 16'h0, 1'b0, "R11");
    exp_all_regs("R11");
    issue(16'h9003, 16'h0, 1'b0, "R11");
    exp_all_regs("R11");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule